// File: doc/BRIEF.md
# Shared-Bus 16-bit Processor Datapath

This block holds the storage and arithmetic of a small load/store processor. Every transfer between its registers crosses one 16-bit bus. A separate control sequencer, not part of this block, drives a set of control inputs each cycle. These inputs pick the source that drives the bus, the registers that capture it, the ALU operation, and the settings of the PC and memory-address multiplexers. The block holds an eight-entry register file, an ALU, the program counter, the instruction register, the memory address and data registers, an address adder, and a three-flag condition-code register.

External memory connects through the address register and the data register. The data register loads either the memory read data or the bus value. The bus is a one-hot multiplexer and not a set of tri-states. Driver indices are: 0 for the ALU result, 1 for the PC, 2 for the data register, and 3 for the address-mux output. When no driver is enabled, the bus reads zero.

Top module: `dp_core`

## Requirements
- R1: When exactly one bit of `bus_drv` is set, the bus carries that source: bit 0 the ALU result, bit 1 the PC, bit 2 the data register, bit 3 the address-mux output. With no bit set, the bus is zero. At most one bit may be set in any cycle.
- R2: PC, IR, MAR and MDR change only on a clock edge where their own load enable is high. IR captures the bus value.
- R3: The register file writes the bus value into entry `dr` only when `ld_reg` is high. `sr1` and `sr2` read two entries at the same time, without waiting for a clock edge.
- R4: `alu_op` selects the ALU operation: 0 is A+B, 1 is A AND B, 2 is NOT A, and 3 passes A. A is read port 1. B is read port 2, or, when `alu_b_imm` is high, IR[4:0] sign-extended.
- R5: With `ld_pc` high, `pc_sel` selects the next PC: 0 gives PC+1, 1 gives the address-adder output, and 2 gives the bus value.
- R6: `mar_sel` 0 selects IR[7:0] zero-extended. `mar_sel` 1 selects the address-adder output. This selection feeds MAR and bus driver 3.
- R7: The address adder sums a base and an offset. The base is the PC, or read port 1 when `base_sel` is high. The offset is IR[5:0] sign-extended, or IR[8:0] sign-extended when `off_sel` is high.
- R8: `cc_nzp` is {N,Z,P} and always has exactly one bit set. When `ld_cc` is high, it takes N if bus bit 15 is 1, Z if the bus is zero, and P otherwise. When `ld_cc` is low, it holds.
- R9: When `ld_mdr` is high, MDR loads `mem_rdata` if `mdr_sel` is 1 and the bus if `mdr_sel` is 0. `mem_addr` shows MAR and `mem_wdata` shows MDR.
- R10: Reset, which is synchronous and active high, sets PC to RESET_PC (default 0), sets IR, MAR and MDR to 0, and sets `cc_nzp` to Z (3'b010).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_drv | input | 4 | One-hot bus driver select |
| ld_ir | input | 1 | IR load enable |
| ld_pc | input | 1 | PC load enable |
| ld_mar | input | 1 | MAR load enable |
| ld_mdr | input | 1 | MDR load enable |
| ld_reg | input | 1 | Register-file write enable |
| ld_cc | input | 1 | Condition-code load enable |
| sr1 | input | 3 | Read port 1 index |
| sr2 | input | 3 | Read port 2 index |
| dr | input | 3 | Write index |
| alu_op | input | 2 | ALU operation |
| alu_b_imm | input | 1 | ALU operand B from IR immediate |
| pc_sel | input | 2 | PC source select |
| mar_sel | input | 1 | MAR source select |
| base_sel | input | 1 | Address-adder base select |
| off_sel | input | 1 | Address-adder offset width select |
| mdr_sel | input | 1 | MDR source: 1 memory, 0 bus |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 16 | MAR contents |
| mem_wdata | output | 16 | MDR contents |
| bus_out | output | 16 | Current bus value |
| pc_out | output | 16 | PC contents |
| ir_out | output | 16 | IR contents |
| cc_nzp | output | 3 | Flags {N,Z,P} |

## Verification
The bench drives negative offsets in both offset widths and a positive 6-bit offset. A design that zero-extends an offset, or takes its sign from the wrong bit, produces addresses that miss by hundreds of words. It checks the condition code on a negative, a zero and a positive bus value, then drives a negative value with `ld_cc` low. A flag register that ignores its enable would switch to N. It also holds every load enable low while the bus and the memory data are active, and checks that no register moved. A register with a wrong enable shows up as changed state. Finally, it reads every register-file entry through both ports and tests both sources of MDR, so crossed indices or a swapped multiplexer input show as wrong values.

// File: rtl/dp_pkg.sv
package dp_pkg;
  typedef enum logic [1:0] {ALU_ADD = 2'd0, ALU_AND = 2'd1, ALU_NOT = 2'd2, ALU_PASS = 2'd3} alu_op_e;
  typedef enum logic [1:0] {PC_INC = 2'd0, PC_ADDR = 2'd1, PC_BUS = 2'd2} pc_sel_e;
  localparam int DRV_ALU  = 0;
  localparam int DRV_PC   = 1;
  localparam int DRV_MDR  = 2;
  localparam int DRV_MARX = 3;
  localparam int DRV_N    = 4;
endpackage

// File: rtl/dp_regfile.sv
module dp_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [DW-1:0] wd,
  input  logic [AW-1:0] ra1,
  input  logic [AW-1:0] ra2,
  output logic [DW-1:0] rd1,
  output logic [DW-1:0] rd2
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
  end

  assign rd1 = mem[ra1];
  assign rd2 = mem[ra2];
endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DW = 16
) (
  input  logic [1:0]    op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  import dp_pkg::*;
  always_comb begin
    unique case (alu_op_e'(op))
      ALU_ADD: y = a + b;
      ALU_AND: y = a & b;
      ALU_NOT: y = ~a;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/dp_addr_gen.sv
module dp_addr_gen #(
  parameter int DW = 16
) (
  input  logic          base_sel,
  input  logic          off_sel,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] rd1,
  input  logic [8:0]    ofs_field,
  output logic [DW-1:0] sum
);
  logic [DW-1:0] base, ofs;
  assign base = base_sel ? rd1 : pc;
  assign ofs  = off_sel ? {{(DW-9){ofs_field[8]}}, ofs_field[8:0]}
                        : {{(DW-6){ofs_field[5]}}, ofs_field[5:0]};
  assign sum  = base + ofs;
endmodule

// File: rtl/dp_core.sv
module dp_core #(
  parameter int DW = 16,
  parameter int REGS = 8,
  parameter logic [DW-1:0] RESET_PC = '0,
  localparam int AW = $clog2(REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [3:0]    bus_drv,
  input  logic          ld_ir,
  input  logic          ld_pc,
  input  logic          ld_mar,
  input  logic          ld_mdr,
  input  logic          ld_reg,
  input  logic          ld_cc,
  input  logic [AW-1:0] sr1,
  input  logic [AW-1:0] sr2,
  input  logic [AW-1:0] dr,
  input  logic [1:0]    alu_op,
  input  logic          alu_b_imm,
  input  logic [1:0]    pc_sel,
  input  logic          mar_sel,
  input  logic          base_sel,
  input  logic          off_sel,
  input  logic          mdr_sel,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] ir_out,
  output logic [2:0]    cc_nzp
);
  import dp_pkg::*;

  logic [DW-1:0] pc_q, ir_q, mar_q, mdr_q;
  logic [2:0]    cc_q;
  logic [DW-1:0] rd1, rd2, alu_b, alu_y, addr_sum, marx, pc_nxt, bus;
  logic [DW-1:0] src [DRV_N];
  logic [2:0]    cc_nxt;

  dp_regfile #(.DW(DW), .DEPTH(REGS)) u_rf (
    .clk(clk), .we(ld_reg), .wa(dr), .wd(bus),
    .ra1(sr1), .ra2(sr2), .rd1(rd1), .rd2(rd2)
  );

  assign alu_b = alu_b_imm ? {{(DW-5){ir_q[4]}}, ir_q[4:0]} : rd2;

  dp_alu #(.DW(DW)) u_alu (.op(alu_op), .a(rd1), .b(alu_b), .y(alu_y));

  dp_addr_gen #(.DW(DW)) u_agen (
    .base_sel(base_sel), .off_sel(off_sel), .pc(pc_q), .rd1(rd1),
    .ofs_field(ir_q[8:0]), .sum(addr_sum)
  );

  assign marx = mar_sel ? addr_sum : {{(DW-8){1'b0}}, ir_q[7:0]};

  // one-hot bus driver mux
  assign src[DRV_ALU]  = alu_y;
  assign src[DRV_PC]   = pc_q;
  assign src[DRV_MDR]  = mdr_q;
  assign src[DRV_MARX] = marx;

  always_comb begin
    bus = '0;
    for (int i = 0; i < DRV_N; i++) begin
      if (bus_drv[i]) bus = bus | src[i];
    end
  end

  always_comb begin
    unique case (pc_sel_e'(pc_sel))
      PC_INC:  pc_nxt = pc_q + 1'b1;
      PC_ADDR: pc_nxt = addr_sum;
      default: pc_nxt = bus;
    endcase
  end

  // flag generation from the bus value
  always_comb begin
    if (bus[DW-1])      cc_nxt = 3'b100;
    else if (bus == '0) cc_nxt = 3'b010;
    else                cc_nxt = 3'b001;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= RESET_PC;
      ir_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      cc_q  <= 3'b010;
    end else begin
      if (ld_pc)  pc_q  <= pc_nxt;
      if (ld_ir)  ir_q  <= bus;
      if (ld_mar) mar_q <= marx;
      if (ld_mdr) mdr_q <= mdr_sel ? mem_rdata : bus;
      if (ld_cc)  cc_q  <= cc_nxt;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign bus_out   = bus;
  assign pc_out    = pc_q;
  assign ir_out    = ir_q;
  assign cc_nzp    = cc_q;
endmodule

// File: rtl/dp_core_chk.sv
module dp_core_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    bus_drv,
  input logic          ld_ir,
  input logic          ld_pc,
  input logic          ld_mar,
  input logic          ld_cc,
  input logic [1:0]    pc_sel,
  input logic [DW-1:0] bus_out,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] ir_out,
  input logic [DW-1:0] mem_addr,
  input logic [2:0]    cc_nzp
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) $onehot0(bus_drv)); // R1
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (rst) (bus_drv == 4'b0) |-> (bus_out == '0)); // R1
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_pc |=> $stable(pc_out)); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_ir |=> $stable(ir_out)); // R2
  AST_MAR_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_mar |=> $stable(mem_addr)); // R2
  AST_IR_LOAD: assert property (@(posedge clk) disable iff (rst) ld_ir |=> (ir_out == $past(bus_out))); // R2
  AST_PC_INC: assert property (@(posedge clk) disable iff (rst) (ld_pc && pc_sel == 2'd0) |=> (pc_out == $past(pc_out) + 1'b1)); // R5
  AST_CC_ONEHOT: assert property (@(posedge clk) disable iff (rst) $countones(cc_nzp) == 1); // R8
  AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst) !ld_cc |=> $stable(cc_nzp)); // R8
endmodule

bind dp_core dp_core_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .bus_drv(bus_drv), .ld_ir(ld_ir), .ld_pc(ld_pc),
  .ld_mar(ld_mar), .ld_cc(ld_cc), .pc_sel(pc_sel), .bus_out(bus_out),
  .pc_out(pc_out), .ir_out(ir_out), .mem_addr(mem_addr), .cc_nzp(cc_nzp)
);

// File: tb/dp_core_tb.sv
module dp_core_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_drv = '0;
  logic        ld_ir = 0, ld_pc = 0, ld_mar = 0, ld_mdr = 0, ld_reg = 0, ld_cc = 0;
  logic [2:0]  sr1 = '0, sr2 = '0, dr = '0;
  logic [1:0]  alu_op = '0, pc_sel = '0;
  logic        alu_b_imm = 0, mar_sel = 0, base_sel = 0, off_sel = 0, mdr_sel = 0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] mem_addr, mem_wdata, bus_out, pc_out, ir_out;
  logic [2:0]  cc_nzp;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dp_core u_dut (
    .clk(clk), .rst(rst), .bus_drv(bus_drv), .ld_ir(ld_ir), .ld_pc(ld_pc),
    .ld_mar(ld_mar), .ld_mdr(ld_mdr), .ld_reg(ld_reg), .ld_cc(ld_cc),
    .sr1(sr1), .sr2(sr2), .dr(dr), .alu_op(alu_op), .alu_b_imm(alu_b_imm),
    .pc_sel(pc_sel), .mar_sel(mar_sel), .base_sel(base_sel), .off_sel(off_sel),
    .mdr_sel(mdr_sel), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .bus_out(bus_out), .pc_out(pc_out), .ir_out(ir_out),
    .cc_nzp(cc_nzp)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  task automatic clr();
    bus_drv = '0; ld_ir = 0; ld_pc = 0; ld_mar = 0; ld_mdr = 0; ld_reg = 0; ld_cc = 0;
    alu_op = 2'd0; alu_b_imm = 0; pc_sel = 2'd0; mar_sel = 0; base_sel = 0;
    off_sel = 0; mdr_sel = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    clr();
  endtask

  task automatic mdr_from_mem(input logic [15:0] v);
    mem_rdata = v; mdr_sel = 1; ld_mdr = 1;
    step();
  endtask

  task automatic put_reg(input int r, input logic [15:0] v);
    mdr_from_mem(v);
    bus_drv = 4'b0100; dr = 3'(r); ld_reg = 1;
    step();
  endtask

  task automatic put_ir(input logic [15:0] v);
    mdr_from_mem(v);
    bus_drv = 4'b0100; ld_ir = 1;
    step();
  endtask

  task automatic put_pc(input logic [15:0] v);
    mdr_from_mem(v);
    bus_drv = 4'b0100; pc_sel = 2'd2; ld_pc = 1;
    step();
  endtask

  function automatic logic [15:0] rval(input int i);
    return 16'(i * 16'h1111);
  endfunction

  task automatic t_reset();
    chk("R10 pc", pc_out, 16'h0000);
    chk("R10 ir", ir_out, 16'h0000);
    chk("R10 mar", mem_addr, 16'h0000);
    chk("R10 mdr", mem_wdata, 16'h0000);
    chk("R10 cc", {13'b0, cc_nzp}, 16'h0002);
    #1 chk("R1 idle bus", bus_out, 16'h0000);
  endtask

  task automatic t_regfile();
    for (int i = 0; i < 8; i++) put_reg(i, rval(i));
    for (int i = 0; i < 8; i++) begin
      bus_drv = 4'b0001; alu_op = 2'd3; sr1 = 3'(i);
      #1 chk("R3 read port1", bus_out, rval(i));
      alu_op = 2'd0; sr1 = 3'd0; sr2 = 3'(i);
      #1 chk("R3 read port2", bus_out, rval(i));
      clr();
    end
  endtask

  task automatic t_alu();
    bus_drv = 4'b0001; sr1 = 3'd3; sr2 = 3'd5;
    alu_op = 2'd0; #1 chk("R4 add", bus_out, 16'h8888);
    alu_op = 2'd1; #1 chk("R4 and", bus_out, 16'h1111);
    alu_op = 2'd2; #1 chk("R4 not", bus_out, 16'hCCCC);
    clr();
    put_ir(16'h001F);
    bus_drv = 4'b0001; sr1 = 3'd3; alu_op = 2'd0; alu_b_imm = 1;
    #1 chk("R4 imm negative", bus_out, 16'h3332);
    clr();
    put_ir(16'h000F);
    bus_drv = 4'b0001; sr1 = 3'd3; alu_op = 2'd0; alu_b_imm = 1;
    #1 chk("R4 imm positive", bus_out, 16'h3342);
    clr();
  endtask

  task automatic t_cc();
    bus_drv = 4'b0001; sr1 = 3'd3; alu_op = 2'd2; ld_cc = 1; step();
    chk("R8 negative", {13'b0, cc_nzp}, 16'h0004);
    bus_drv = 4'b0001; sr1 = 3'd0; alu_op = 2'd3; ld_cc = 1; step();
    chk("R8 zero", {13'b0, cc_nzp}, 16'h0002);
    bus_drv = 4'b0001; sr1 = 3'd3; alu_op = 2'd3; ld_cc = 1; step();
    chk("R8 positive", {13'b0, cc_nzp}, 16'h0001);
    bus_drv = 4'b0001; sr1 = 3'd3; alu_op = 2'd2; ld_cc = 0; step();
    chk("R8 hold without enable", {13'b0, cc_nzp}, 16'h0001);
  endtask

  task automatic t_mdr();
    mdr_from_mem(16'h00AB);
    chk("R9 mdr from memory", mem_wdata, 16'h00AB);
    bus_drv = 4'b0001; sr1 = 3'd6; alu_op = 2'd3; mdr_sel = 0; ld_mdr = 1; step();
    chk("R9 mdr from bus", mem_wdata, 16'h6666);
    bus_drv = 4'b0100;
    #1 chk("R1 mdr driver", bus_out, 16'h6666);
    clr();
  endtask

  task automatic t_addr();
    put_pc(16'h3000);
    put_ir(16'h0123);
    bus_drv = 4'b1000; mar_sel = 0;
    #1 chk("R1 address-mux driver", bus_out, 16'h0023);
    ld_mar = 1; step();
    chk("R6 zero-extended field", mem_addr, 16'h0023);
    mar_sel = 1; ld_mar = 1; step();
    chk("R7 pc + off6 negative", mem_addr, 16'h2FE3);
    mar_sel = 1; off_sel = 1; ld_mar = 1; step();
    chk("R7 pc + off9 negative", mem_addr, 16'h2F23);
    mar_sel = 1; base_sel = 1; sr1 = 3'd2; ld_mar = 1; step();
    chk("R7 reg + off6", mem_addr, 16'h2205);
    mar_sel = 1; base_sel = 1; sr1 = 3'd2; off_sel = 1; ld_mar = 1; step();
    chk("R6 adder source", mem_addr, 16'h2145);
    put_ir(16'h0015);
    mar_sel = 1; ld_mar = 1; step();
    chk("R7 pc + off6 positive", mem_addr, 16'h3015);
  endtask

  task automatic t_pc();
    put_pc(16'h3000);
    chk("R5 pc from bus", pc_out, 16'h3000);
    pc_sel = 2'd0; ld_pc = 1; step();
    chk("R5 pc increment", pc_out, 16'h3001);
    put_ir(16'h0123);
    pc_sel = 2'd1; off_sel = 1; ld_pc = 1; step();
    chk("R5 pc from adder", pc_out, 16'h2F24);
    bus_drv = 4'b0010;
    #1 chk("R1 pc driver", bus_out, 16'h2F24);
    clr();
    bus_drv = 4'b0001; sr1 = 3'd7; alu_op = 2'd3; pc_sel = 2'd2; ld_pc = 1; step();
    chk("R5 pc from alu bus", pc_out, 16'h7777);
  endtask

  task automatic t_hold();
    put_pc(16'h1234);
    put_ir(16'h0055);
    mar_sel = 0; ld_mar = 1; step();
    mdr_from_mem(16'h0AAA);
    bus_drv = 4'b0001; sr1 = 3'd5; alu_op = 2'd3;
    mdr_sel = 1; mem_rdata = 16'hFFFF; dr = 3'd1; pc_sel = 2'd2;
    step();
    chk("R2 pc hold", pc_out, 16'h1234);
    chk("R2 ir hold", ir_out, 16'h0055);
    chk("R2 mar hold", mem_addr, 16'h0055);
    chk("R2 mdr hold", mem_wdata, 16'h0AAA);
    bus_drv = 4'b0001; sr1 = 3'd1; alu_op = 2'd3;
    #1 chk("R3 no write without enable", bus_out, 16'h1111);
    clr();
  endtask

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_regfile();
    t_alu();
    t_cc();
    t_mdr();
    t_addr();
    t_pc();
    t_hold();
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end
endmodule